// File: doc/BRIEF.md
# Card Asynchronous Character Receiver

This block receives characters from the half-duplex I/O line of a contact chip card. Each character on the line is ten bit times long: a low start bit, eight information bits and an even-parity bit. The bit time (one elementary time unit, etu) is given in clock cycles on an input. The usual value while the card answers a reset is 372. The receiver hunts for a falling edge and confirms the start bit at half an etu. It then takes each later bit in the middle of its bit time and judges the whole character once the parity bit is in.

The first character after reset must be the initial byte, and the receiver learns the coding convention from it. In direct coding a high level is a one and the least significant bit comes first. In inverse coding a low level is a one and the most significant bit comes first. Once the convention is known, every later character is decoded with it. A character with a parity error is not delivered. Instead the receiver pulls the line low inside the guard time so that the card repeats the character. The line model is open drain: the block only ever drives low or releases the line.

States: `ST_HUNT` (wait for a falling edge), `ST_CONFIRM` (recheck the line at 0.5 etu), `ST_SHIFT` (nine mid-bit samples, one etu apart), `ST_JUDGE` (one cycle to decide), `ST_ERR_WAIT` (wait until 10.5 etu) and `ST_ERR_DRIVE` (pull the line low for 1.5 etu). The transitions are:
- `ST_HUNT` to `ST_CONFIRM` on a falling edge.
- `ST_CONFIRM` to `ST_SHIFT` if the line is still low, or back to `ST_HUNT` if it is high again.
- `ST_SHIFT` to `ST_JUDGE` after the ninth sample.
- `ST_JUDGE` to `ST_ERR_WAIT` on a parity error, otherwise to `ST_HUNT`.
- `ST_ERR_WAIT` to `ST_ERR_DRIVE`, then `ST_ERR_DRIVE` to `ST_HUNT`.

Top module: `card_char_rx`

## Requirements
- R1: After reset, `rx_valid`, `parity_err`, `format_err`, `conv_known`, `conv_inverse` and `io_drive_low` are all 0.
- R2: A low level on the line that has ended before half an etu after its falling edge is not taken as a start bit, and no character is reported for it.
- R3: When the convention is unknown, the nine levels after the start bit, in arrival order high,high,low,high,high,high,low,low,high, select direct coding. `conv_known` goes to 1, `conv_inverse` stays 0, and 0x3B is delivered with a one-cycle `rx_valid`.
- R4: When the convention is unknown, the levels high,high,low,low,low,low,low,low,high select inverse coding. `conv_known` and `conv_inverse` go to 1, and 0x3F is delivered with `rx_valid`.
- R5: When the convention is unknown, any other first character gives a one-cycle `format_err`, no `rx_valid` and no error pulse on the line. The convention stays unknown, so the next character is again taken as the initial byte.
- R6: In direct coding, a high level is 1 and the first data bit is bit 0 of `rx_byte`. A character with correct parity is delivered with `rx_valid` high for exactly one cycle.
- R7: In inverse coding, a low level is 1 and the first data bit is bit 7 of `rx_byte`. The parity bit is also taken inverted.
- R8: The nine decoded bits after the start bit must hold an even number of ones. If they do not, `parity_err` pulses for one cycle and `rx_valid` stays 0.
- R9: After a parity error, `io_drive_low` rises 10.5 etu after the detected start edge, stays high for exactly 1.5 etu (etu + etu/2 cycles), and then releases the line.
- R10: All bit timing follows `etu_cycles`. Characters sent at 372 cycles per etu are received like characters at any other setting.
- R11: `io_drive_low` is never asserted except in the error pulse that follows a parity error.
- R12: Once learned, the convention holds until reset, whatever the later characters carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; also starts a new answer |
| etu_cycles | input | ETU_W (16) | Clock cycles per elementary time unit, at least 8 |
| io_in | input | 1 | Level seen on the card I/O line (1 = high) |
| io_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| rx_byte | output | 8 | Last decoded byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new character |
| parity_err | output | 1 | One-cycle strobe: a character failed parity |
| format_err | output | 1 | One-cycle strobe: the initial byte matched neither convention |
| conv_known | output | 1 | The coding convention has been learned |
| conv_inverse | output | 1 | 1 = inverse coding, 0 = direct coding |

## Verification
The main decoding is tried with one byte table sent first under direct coding and then under inverse coding. The table mixes all-zero, all-one, alternating, single-bit and bit-order-asymmetric bytes, so a wrong bit order, a missing inversion or a wrong parity sense gives a different byte or a false parity error. The same table includes bytes with the parity bit flipped. These separate delivery from rejection and show that the error pulse starts and ends at the right time. Separate directed runs cover a non-matching initial byte followed by a good one, a short glitch, and a run at 372 cycles per etu. Together they show that the start confirmation, the learning rule and the timer scaling work on their own.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 1;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CONFIRM,
        ST_SHIFT,
        ST_JUDGE,
        ST_ERR_WAIT,
        ST_ERR_DRIVE
    } rx_state_t;

    // Raw line levels after the start bit, first arrival in bit 0.
    localparam logic [FRAME_BITS-1:0] TS_DIRECT_LEVELS  = 9'b1_0011_1011;
    localparam logic [FRAME_BITS-1:0] TS_INVERSE_LEVELS = 9'b1_0000_0011;
    localparam logic [DATA_BITS-1:0]  TS_DIRECT_BYTE    = 8'h3B;
    localparam logic [DATA_BITS-1:0]  TS_INVERSE_BYTE   = 8'h3F;

endpackage

// File: rtl/card_rx_line_sync.sv
module card_rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_fall
);

    logic [STAGES-1:0] chain;
    logic              line_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= chain[STAGES-1];
    end

    assign line_s    = chain[STAGES-1];
    assign line_fall = line_prev & ~chain[STAGES-1];

endmodule

// File: rtl/card_rx_etu_timer.sv
module card_rx_etu_timer #(
    parameter int ETU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ETU_W:0]   load_val,
    output logic             expire
);

    logic [ETU_W:0] cnt;
    logic           running;

    assign expire = running && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val - 1'b1;
            running <= 1'b1;
        end else if (expire) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/card_rx_decoder.sv
module card_rx_decoder
    import card_rx_pkg::*;
(
    input  logic [FRAME_BITS-1:0] levels,
    input  logic                  inverse,
    output logic [DATA_BITS-1:0]  data,
    output logic                  parity_ok,
    output logic                  is_ts_direct,
    output logic                  is_ts_inverse
);

    logic [DATA_BITS-1:0] direct_data;
    logic [DATA_BITS-1:0] inverse_data;

    generate
        for (genvar g = 0; g < DATA_BITS; g++) begin : g_bit
            assign direct_data[g]               = levels[g];
            assign inverse_data[DATA_BITS-1-g]  = ~levels[g];
        end
    endgenerate

    // Nine bits: even ones in direct means even highs; in inverse, even lows = odd highs.
    assign parity_ok     = inverse ? (^levels) : ~(^levels);
    assign data          = inverse ? inverse_data : direct_data;
    assign is_ts_direct  = (levels == TS_DIRECT_LEVELS);
    assign is_ts_inverse = (levels == TS_INVERSE_LEVELS);

endmodule

// File: rtl/card_char_rx.sv
module card_char_rx
    import card_rx_pkg::*;
#(
    parameter int ETU_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ETU_W-1:0] etu_cycles,
    input  logic             io_in,
    output logic             io_drive_low,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             parity_err,
    output logic             format_err,
    output logic             conv_known,
    output logic             conv_inverse
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    rx_state_t state_q, state_d;

    logic                  line_s, line_fall;
    logic                  tmr_load, tmr_expire;
    logic [ETU_W:0]        tmr_val;
    logic [ETU_W:0]        etu_full, etu_half;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] levels;
    logic                  shift_en;
    logic [DATA_BITS-1:0]  dec_data;
    logic                  dec_par_ok, dec_ts_dir, dec_ts_inv;

    assign etu_full = {1'b0, etu_cycles};
    assign etu_half = {2'b00, etu_cycles[ETU_W-1:1]};

    card_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (io_in),
        .line_s    (line_s),
        .line_fall (line_fall)
    );

    card_rx_etu_timer #(.ETU_W(ETU_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    card_rx_decoder u_dec (
        .levels        (levels),
        .inverse       (conv_inverse),
        .data          (dec_data),
        .parity_ok     (dec_par_ok),
        .is_ts_direct  (dec_ts_dir),
        .is_ts_inverse (dec_ts_inv)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = etu_full;
        shift_en = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (line_fall) begin
                    tmr_load = 1'b1;
                    tmr_val  = etu_half;
                    state_d  = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (tmr_expire) begin
                    if (!line_s) begin
                        tmr_load = 1'b1;
                        state_d  = ST_SHIFT;
                    end else begin
                        state_d  = ST_HUNT;
                    end
                end
            end
            ST_SHIFT: begin
                if (tmr_expire) begin
                    shift_en = 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        state_d = ST_JUDGE;
                    end else begin
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_JUDGE: begin
                if (conv_known && !dec_par_ok) begin
                    // one cycle spent here, so wait one cycle less
                    tmr_load = 1'b1;
                    tmr_val  = etu_full - 1'b1;
                    state_d  = ST_ERR_WAIT;
                end else begin
                    state_d  = ST_HUNT;
                end
            end
            ST_ERR_WAIT: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    tmr_val  = etu_full + etu_half;
                    state_d  = ST_ERR_DRIVE;
                end
            end
            ST_ERR_DRIVE: begin
                if (tmr_expire) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // Sample shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            levels  <= '1;
            bit_cnt <= '0;
        end else if (state_q == ST_CONFIRM) begin
            bit_cnt <= '0;
        end else if (shift_en) begin
            levels  <= {line_s, levels[FRAME_BITS-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_drive_low <= 1'b0;
            rx_byte      <= '0;
            rx_valid     <= 1'b0;
            parity_err   <= 1'b0;
            format_err   <= 1'b0;
            conv_known   <= 1'b0;
            conv_inverse <= 1'b0;
        end else begin
            rx_valid     <= 1'b0;
            parity_err   <= 1'b0;
            format_err   <= 1'b0;
            io_drive_low <= (state_d == ST_ERR_DRIVE);
            if (state_q == ST_JUDGE) begin
                if (!conv_known) begin
                    if (dec_ts_dir) begin
                        conv_known   <= 1'b1;
                        conv_inverse <= 1'b0;
                        rx_byte      <= TS_DIRECT_BYTE;
                        rx_valid     <= 1'b1;
                    end else if (dec_ts_inv) begin
                        conv_known   <= 1'b1;
                        conv_inverse <= 1'b1;
                        rx_byte      <= TS_INVERSE_BYTE;
                        rx_valid     <= 1'b1;
                    end else begin
                        format_err   <= 1'b1;
                    end
                end else if (dec_par_ok) begin
                    rx_byte  <= dec_data;
                    rx_valid <= 1'b1;
                end else begin
                    parity_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/card_char_rx_chk.sv
module card_char_rx_chk #(
    parameter int ETU_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ETU_W-1:0] etu_cycles,
    input logic             io_drive_low,
    input logic             rx_valid,
    input logic             parity_err,
    input logic             format_err,
    input logic             conv_known,
    input logic             conv_inverse
);

    logic [ETU_W:0] since_perr;
    logic [ETU_W:0] drive_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_perr <= '1;
            drive_run  <= '0;
        end else begin
            if (parity_err)          since_perr <= {{ETU_W{1'b0}}, 1'b1};
            else if (~&since_perr)   since_perr <= since_perr + 1'b1;
            if (io_drive_low)        drive_run  <= drive_run + 1'b1;
            else                     drive_run  <= '0;
        end
    end

    // R6: delivery strobe lasts one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: a rejected character is never delivered
    a_r8_no_deliver_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> !rx_valid);

    // R5: format error only while convention unknown
    a_r5_format_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        format_err |-> !conv_known);

    // R12: convention sticky once learned
    a_r12_conv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        conv_known |=> (conv_known && $stable(conv_inverse)));

    // R11: line driven only after the convention is known
    a_r11_drive_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive_low |-> conv_known);

    // R9: pulse starts one etu after the parity error strobe (10.5 etu after start)
    a_r9_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_drive_low) |-> (since_perr == ({1'b0, etu_cycles} - 1'b1)));

    // R9: pulse lasts 1.5 etu
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_drive_low) |-> (drive_run == ({1'b0, etu_cycles} + {2'b00, etu_cycles[ETU_W-1:1]})));

endmodule

bind card_char_rx card_char_rx_chk #(.ETU_W(ETU_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .etu_cycles   (etu_cycles),
    .io_drive_low (io_drive_low),
    .rx_valid     (rx_valid),
    .parity_err   (parity_err),
    .format_err   (format_err),
    .conv_known   (conv_known),
    .conv_inverse (conv_inverse)
);

// File: tb/card_char_rx_test.sv
module card_char_rx_test;

    localparam int NV = 9;
    // {flip_parity, data}
    localparam logic [8:0] VEC [NV] = '{
        9'h000, 9'h0FF, 9'h0A5, 9'h05A, 9'h001, 9'h080, 9'h03F, 9'h1C3, 9'h17E
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] etu = 16'd32;
    logic        line_drv = 1'b1;
    logic        io_drive_low, rx_valid, parity_err, format_err, conv_known, conv_inverse;
    logic [7:0]  rx_byte;
    wire         io_line = line_drv & ~io_drive_low;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int n_valid = 0, n_perr = 0, n_ferr = 0, n_drive = 0, drive_rise = -1;
    logic prev_drive = 1'b0;
    logic [7:0] last_byte = '0;
    int b_valid, b_perr, b_ferr, b_drive, t_start;

    always #10 clk = ~clk;

    card_char_rx uut (
        .clk(clk), .rst_n(rst_n), .etu_cycles(etu), .io_in(io_line),
        .io_drive_low(io_drive_low), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .parity_err(parity_err), .format_err(format_err),
        .conv_known(conv_known), .conv_inverse(conv_inverse)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rx_valid) begin n_valid = n_valid + 1; last_byte = rx_byte; end
        if (parity_err) n_perr = n_perr + 1;
        if (format_err) n_ferr = n_ferr + 1;
        if (io_drive_low) n_drive = n_drive + 1;
        if (io_drive_low && !prev_drive) drive_rise = cyc;
        prev_drive = io_drive_low;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] levels(input logic [7:0] d, input logic inv, input logic flip);
        logic [8:0] l;
        logic p;
        for (int i = 0; i < 8; i++) l[i] = inv ? ~d[7-i] : d[i];
        p = (^d) ^ flip;
        l[8] = inv ? ~p : p;
        return l;
    endfunction

    task automatic send_lev(input logic [8:0] l);
        b_valid = n_valid; b_perr = n_perr; b_ferr = n_ferr; b_drive = n_drive;
        @(negedge clk);
        t_start = cyc;
        line_drv = 1'b0;
        repeat (etu) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            line_drv = l[i];
            repeat (etu) @(negedge clk);
        end
        line_drv = 1'b1;
        repeat (3 * etu) @(negedge clk);
    endtask

    task automatic do_reset();
        line_drv = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_good(input logic [7:0] d, input string tag);
        check(n_valid - b_valid == 1, tag, n_valid - b_valid, 1);
        check(last_byte == d, tag, last_byte, d);
        check(n_perr == b_perr, tag, n_perr - b_perr, 0);
        check(n_drive == b_drive, {tag, "/R11"}, n_drive - b_drive, 0);
    endtask

    task automatic walk_table(input logic inv, input string tag);
        for (int k = 0; k < NV; k++) begin
            send_lev(levels(VEC[k][7:0], inv, VEC[k][8]));
            if (VEC[k][8]) begin
                check(n_perr - b_perr == 1, "R8 parity_err", n_perr - b_perr, 1);
                check(n_valid == b_valid, "R8 no valid", n_valid - b_valid, 0);
                check(n_drive - b_drive == etu + etu / 2, "R9 pulse length",
                      n_drive - b_drive, etu + etu / 2);
                check(drive_rise - t_start >= 10 * etu + etu / 2 &&
                      drive_rise - t_start <= 10 * etu + etu / 2 + 5,
                      "R9 pulse start", drive_rise - t_start, 10 * etu + etu / 2);
            end else begin
                expect_good(VEC[k][7:0], tag);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check({rx_valid, parity_err, format_err, conv_known, conv_inverse, io_drive_low} == 6'b0,
              "R1 reset outputs", {rx_valid, parity_err, format_err, conv_known, conv_inverse, io_drive_low}, 0);

        // R2 glitch rejected
        b_valid = n_valid; b_ferr = n_ferr;
        @(negedge clk); line_drv = 1'b0;
        repeat (etu / 4) @(negedge clk);
        line_drv = 1'b1;
        repeat (13 * etu) @(negedge clk);
        check(n_valid == b_valid && n_ferr == b_ferr, "R2 glitch", n_valid - b_valid + n_ferr - b_ferr, 0);

        // R5 bad initial byte, then R3 direct initial byte
        send_lev(9'b1_0101_0101);
        check(n_ferr - b_ferr == 1, "R5 format_err", n_ferr - b_ferr, 1);
        check(n_valid == b_valid, "R5 no valid", n_valid - b_valid, 0);
        check(conv_known == 1'b0, "R5 conv unknown", conv_known, 0);
        check(n_drive == b_drive, "R5 no drive", n_drive - b_drive, 0);
        send_lev(9'b1_0011_1011);
        expect_good(8'h3B, "R3 direct TS");
        check(conv_known && !conv_inverse, "R3 conv flags", {conv_known, conv_inverse}, 2);

        // R6 direct decoding table
        walk_table(1'b0, "R6 direct");
        check(conv_known && !conv_inverse, "R12 conv held", {conv_known, conv_inverse}, 2);

        // R4 inverse initial byte, R7 inverse decoding
        do_reset();
        send_lev(9'b1_0000_0011);
        expect_good(8'h3F, "R4 inverse TS");
        check(conv_known && conv_inverse, "R4 conv flags", {conv_known, conv_inverse}, 3);
        walk_table(1'b1, "R7 inverse");
        // direct TS pattern after learning is plain data
        send_lev(9'b1_0011_1011);
        check(conv_inverse == 1'b1, "R12 not relearned", conv_inverse, 1);

        // R10 at 372 cycles per etu
        etu = 16'd372;
        do_reset();
        send_lev(9'b1_0011_1011);
        expect_good(8'h3B, "R10 TS at 372");
        send_lev(levels(8'h96, 1'b0, 1'b0));
        expect_good(8'h96, "R10 byte at 372");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule